// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Bus Interface

This block is the digital half of a 12-bit successive-approximation converter. It decodes the chip enable, active-low chip select, read/convert and byte-address strobes of a host bus. It steps a 12-bit trial code, one bit at a time, against a single comparator bit. It reports a busy status and returns the result on data pins, each with its own output enable. The DAC, comparator, reference and oscillator sit outside the block. The trial code goes out to the DAC, and the comparator answer comes back as one input bit.

When a conversion starts, the byte-address line picks a full 12-bit conversion or a short 8-bit one. After the conversion, the same line picks which byte a narrow host reads. A wide host reads the whole word in one access. A stand-alone mode runs the converter from the read/convert line alone, for systems with no bus decode.

Top module: `sar_bus_ctrl`

## Requirements
- R1: A conversion starts only on the clock where the start condition first becomes true. Outside stand-alone mode the start condition is chip_en=1, chip_sel_n=0 and rd_cnv=0. busy is high from the next clock.
- R2: byte_sel is captured when a conversion starts. 0 selects 12 decisions and 1 selects 8 decisions. Each decision takes BIT_CYC clocks, so busy stays high for exactly decisions*BIT_CYC clocks.
- R3: Bits are decided from MSB to LSB. Before each decision the bit under test is set to 1 in trial_code. cmp_in is sampled on the last clock of the bit period: 1 keeps the bit and 0 clears it. A short conversion leaves result bits 3..0 at 0.
- R4: When busy falls, the result register already holds the final code of that conversion, and the next read returns it.
- R5: A start condition that arises while busy is high is ignored. The running conversion keeps its length and its result.
- R6: db_oe is all zero except one clock after a read condition (chip_en=1, chip_sel_n=0, rd_cnv=1) was sampled with busy low.
- R7: With wide_bus=1, a read drives all 12 pins (db_oe=12'hFFF) with the result.
- R8: With wide_bus=0, a read drives pins 11..4 only (db_oe=12'hFF0). byte_sel=0 returns result[11:4] on those pins. byte_sel=1 returns {result[3:0],4'b0000} on them.
- R9: When the byte selection changes during a read, db_oe is all zero for one clock before the other byte is driven.
- R10: With solo_mode=1, chip_en and chip_sel_n are ignored. A falling rd_cnv starts a 12-bit conversion whatever the value of byte_sel. While rd_cnv is high and busy is low, all 12 pins are driven. The pins are released one clock after rd_cnv goes low.
- R11: During reset, busy and db_oe are 0 and the result register is cleared, so a read straight after reset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_cnv | input | 1 | High: read, low: convert |
| byte_sel | input | 1 | Short-cycle select at start, byte select on read |
| wide_bus | input | 1 | 1: full-word read, 0: two byte reads |
| solo_mode | input | 1 | Stand-alone operation from rd_cnv only |
| cmp_in | input | 1 | Comparator: 1 when input is at or above trial_code |
| trial_code | output | 12 | Code applied to the DAC |
| busy | output | 1 | Conversion in progress |
| db_val | output | 12 | Data pin values |
| db_oe | output | 12 | Per-pin output enable |

## Verification
A wrong bit index or a broken bit-period counter shows up first as a wrong busy width. busy falls early or late by a multiple of BIT_CYC, and this is visible at the end of the conversion. A bad decision shows up as a result that differs from the binary search of the analog value on a known bit position, and the next read exposes it. A wrong length latch shows up as nonzero low bits after a short conversion, or as a 12-bit busy width. Faults in the drive state show up within one clock of a read or a byte change: enables during busy, a missing gap, or a wrong mask.

// File: rtl/sar_bus_pkg.sv
package sar_bus_pkg;
  typedef enum logic [1:0] {
    DRV_OFF   = 2'd0,
    DRV_FULL  = 2'd1,
    DRV_UPPER = 2'd2,
    DRV_LOWER = 2'd3
  } drv_sel_e;
endpackage

// File: rtl/sar_strobe_dec.sv
module sar_strobe_dec
  import sar_bus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     chip_en,
  input  logic     chip_sel_n,
  input  logic     rd_cnv,
  input  logic     byte_sel,
  input  logic     wide_bus,
  input  logic     solo_mode,
  input  logic     busy,
  output logic     start_pulse,
  output logic     start_short,
  output drv_sel_e read_want
);
  logic sel_ok, start_cond, read_cond;
  logic start_seen_q;

  // Strobe qualification; stand-alone mode behaves as permanently selected.
  always_comb begin
    sel_ok      = solo_mode | (chip_en & ~chip_sel_n);
    start_cond  = sel_ok & ~rd_cnv;
    read_cond   = sel_ok & rd_cnv;
    start_pulse = start_cond & ~start_seen_q & ~busy;
    start_short = ~solo_mode & byte_sel;
    if (!read_cond || busy)         read_want = DRV_OFF;
    else if (solo_mode || wide_bus) read_want = DRV_FULL;
    else if (byte_sel)              read_want = DRV_LOWER;
    else                            read_want = DRV_UPPER;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_seen_q <= 1'b0;
    else        start_seen_q <= start_cond;
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8,
  parameter int BIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_short,
  input  logic             cmp_in,
  output logic             busy,
  output logic             decide,
  output logic [RES_W-1:0] trial_code,
  output logic [RES_W-1:0] result
);
  localparam int CNT_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [CNT_W-1:0] CYC_LAST  = CNT_W'(BIT_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_TOP   = IDX_W'(RES_W - 1);
  localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(RES_W - SHORT_W);

  logic [RES_W-1:0] trial_q, trial_n, res_q, res_n, code;
  logic [IDX_W-1:0] idx_q, idx_n, stop_idx;
  logic [CNT_W-1:0] cyc_q, cyc_n;
  logic             busy_q, busy_n, short_q, short_n;

  always_comb begin
    trial_n  = trial_q;
    res_n    = res_q;
    idx_n    = idx_q;
    cyc_n    = cyc_q;
    busy_n   = busy_q;
    short_n  = short_q;
    code     = trial_q;
    decide   = busy_q && (cyc_q == CYC_LAST);
    stop_idx = short_q ? IDX_SHORT : '0;
    if (start) begin
      busy_n  = 1'b1;
      short_n = start_short;
      idx_n   = IDX_TOP;
      cyc_n   = '0;
      trial_n = {1'b1, {(RES_W-1){1'b0}}};
    end else if (decide) begin
      code[idx_q] = cmp_in;
      cyc_n       = '0;
      if (idx_q == stop_idx) begin
        res_n   = code;
        busy_n  = 1'b0;
        trial_n = code;
      end else begin
        code[idx_q - 1'b1] = 1'b1;
        trial_n = code;
        idx_n   = idx_q - 1'b1;
      end
    end else if (busy_q) begin
      cyc_n = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      res_q   <= '0;
      idx_q   <= '0;
      cyc_q   <= '0;
      busy_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      trial_q <= trial_n;
      res_q   <= res_n;
      idx_q   <= idx_n;
      cyc_q   <= cyc_n;
      busy_q  <= busy_n;
      short_q <= short_n;
    end
  end

  assign busy       = busy_q;
  assign trial_code = trial_q;
  assign result     = res_q;
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage
  import sar_bus_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  drv_sel_e         want,
  input  logic [RES_W-1:0] result,
  output drv_sel_e         drv,
  output logic [RES_W-1:0] db_val,
  output logic [RES_W-1:0] db_oe
);
  localparam int LO_BIT = RES_W - BYTE_W;
  localparam int TAIL_W = BYTE_W - LO_BIT;

  drv_sel_e          drv_q, drv_n;
  logic [BYTE_W-1:0] low_byte;

  // One idle clock whenever the driven set of pins would change.
  always_comb begin
    if (want == DRV_OFF)                        drv_n = DRV_OFF;
    else if (drv_q == DRV_OFF || drv_q == want) drv_n = want;
    else                                        drv_n = DRV_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= DRV_OFF;
    else        drv_q <= drv_n;
  end

  always_comb begin
    low_byte = {result[LO_BIT-1:0], {TAIL_W{1'b0}}};
    db_val   = '0;
    db_oe    = '0;
    case (drv_q)
      DRV_FULL: begin
        db_val = result;
        db_oe  = '1;
      end
      DRV_UPPER: begin
        db_val[RES_W-1:LO_BIT] = result[RES_W-1:LO_BIT];
        db_oe[RES_W-1:LO_BIT]  = '1;
      end
      DRV_LOWER: begin
        db_val[RES_W-1:LO_BIT] = low_byte;
        db_oe[RES_W-1:LO_BIT]  = '1;
      end
      default: ;
    endcase
  end

  assign drv = drv_q;
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_bus_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8,
  parameter int BYTE_W  = 8,
  parameter int BIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             chip_sel_n,
  input  logic             rd_cnv,
  input  logic             byte_sel,
  input  logic             wide_bus,
  input  logic             solo_mode,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial_code,
  output logic             busy,
  output logic [RES_W-1:0] db_val,
  output logic [RES_W-1:0] db_oe
);
  logic             start_pulse, start_short, decide_w;
  drv_sel_e         read_want, drv_w;
  logic [RES_W-1:0] result_w;

  sar_strobe_dec u_dec (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
    .rd_cnv(rd_cnv), .byte_sel(byte_sel), .wide_bus(wide_bus),
    .solo_mode(solo_mode), .busy(busy), .start_pulse(start_pulse),
    .start_short(start_short), .read_want(read_want)
  );

  sar_seq #(.RES_W(RES_W), .SHORT_W(SHORT_W), .BIT_CYC(BIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .start_short(start_short),
    .cmp_in(cmp_in), .busy(busy), .decide(decide_w), .trial_code(trial_code),
    .result(result_w)
  );

  sar_out_stage #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .want(read_want), .result(result_w),
    .drv(drv_w), .db_val(db_val), .db_oe(db_oe)
  );
endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk
  import sar_bus_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chip_en,
  input logic             chip_sel_n,
  input logic             rd_cnv,
  input logic             solo_mode,
  input logic             busy,
  input logic             decide,
  input logic [RES_W-1:0] trial_code,
  input logic [RES_W-1:0] db_oe,
  input drv_sel_e         drv
);
  localparam logic [RES_W-1:0] BYTE_MASK = {{BYTE_W{1'b1}}, {(RES_W-BYTE_W){1'b0}}};

  logic sel_ok;
  assign sel_ok = solo_mode | (chip_en & ~chip_sel_n);

  a_r1_start_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sel_ok && !rd_cnv));

  a_r3_trial_moves_on_decision: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(decide)) |-> $stable(trial_code));

  a_r6_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (db_oe != '0) |-> $past(sel_ok && rd_cnv && !busy));

  a_r8_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (db_oe == '0) || (db_oe == '1) || (db_oe == BYTE_MASK));

  a_r9_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    (drv != DRV_OFF && $past(drv) != DRV_OFF) |-> (drv == $past(drv)));
endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
  .rd_cnv(rd_cnv), .solo_mode(solo_mode), .busy(busy), .decide(decide_w),
  .trial_code(trial_code), .db_oe(db_oe), .drv(drv_w)
);

// File: tb/tb_sar_bus_ctrl.sv
module tb_sar_bus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 3;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 6;
  // {analog value, short, wide}
  localparam logic [13:0] VEC [NVEC] = '{
    {12'hA5C, 1'b0, 1'b1}, {12'h000, 1'b0, 1'b1}, {12'hFFF, 1'b0, 1'b0},
    {12'h7FF, 1'b1, 1'b1}, {12'h801, 1'b1, 1'b0}, {12'h3C9, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, chip_sel_n = 1'b1, rd_cnv = 1'b1;
  logic byte_sel = 1'b0, wide_bus = 1'b1, solo_mode = 1'b0;
  logic [11:0] vin = '0;
  logic        cmp_in;
  logic [11:0] trial_code, db_val, db_oe;
  logic        busy;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmp_in = (vin >= trial_code);

  sar_bus_ctrl #(.BIT_CYC(BIT_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .chip_sel_n(chip_sel_n),
    .rd_cnv(rd_cnv), .byte_sel(byte_sel), .wide_bus(wide_bus),
    .solo_mode(solo_mode), .cmp_in(cmp_in), .trial_code(trial_code),
    .busy(busy), .db_val(db_val), .db_oe(db_oe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Start a conversion and count the clocks with busy high.
  task automatic convert(input logic [11:0] v, input logic short_c, input logic mid_restart,
                         output int len);
    @(negedge clk);
    vin = v; chip_en = 1'b1; chip_sel_n = 1'b0; byte_sel = short_c; rd_cnv = 1'b0;
    @(negedge clk);
    rd_cnv = 1'b1;
    len = 0;
    while (busy) begin
      len++;
      if (len == 2) check("R6 no drive while busy", db_oe, 12'h000);
      if (mid_restart && len == 3) begin rd_cnv = 1'b0; byte_sel = ~short_c; end
      if (mid_restart && len == 4) rd_cnv = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    int len;
    logic [11:0] exp_res;
    repeat (3) @(negedge clk);
    check("R11 busy in reset", busy, 0);
    check("R11 oe in reset", db_oe, 12'h000);
    rst_n = 1'b1;
    // R11: read straight after reset returns zero
    @(negedge clk); chip_en = 1'b1; chip_sel_n = 1'b0; wide_bus = 1'b1;
    @(negedge clk);
    check("R11 result cleared oe", db_oe, 12'hFFF);
    check("R11 result cleared val", db_val, 12'h000);
    // R6: deselected read releases pins
    chip_sel_n = 1'b1;
    @(negedge clk);
    check("R6 released on deselect", db_oe, 12'h000);

    // R1: no start without both enables
    rd_cnv = 1'b0; chip_en = 1'b1; chip_sel_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 no start cs high", busy, 0);
    chip_en = 1'b0; chip_sel_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 no start ce low", busy, 0);
    rd_cnv = 1'b1;
    @(negedge clk);

    // Vector table: R2 R3 R4 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      logic [11:0] v;
      logic sh, wd;
      {v, sh, wd} = VEC[i];
      exp_res = sh ? (v & 12'hFF0) : v;
      convert(v, sh, 1'b0, len);
      check("R2 busy length", len, (sh ? 8 : 12) * BIT_CYC);
      wide_bus = wd; byte_sel = 1'b0;
      @(negedge clk);
      if (wd) begin
        check("R7 full oe", db_oe, 12'hFFF);
        check("R3 R4 full value", db_val, exp_res);
      end else begin
        check("R8 upper oe", db_oe, 12'hFF0);
        check("R8 upper value", db_val[11:4], exp_res[11:4]);
        byte_sel = 1'b1;
        @(negedge clk);
        check("R9 gap on byte change", db_oe, 12'h000);
        @(negedge clk);
        check("R8 lower oe", db_oe, 12'hFF0);
        check("R8 lower value", db_val[11:4], {exp_res[3:0], 4'h0});
      end
      chip_en = 1'b0;
      @(negedge clk);
    end

    // R5: start while busy is ignored
    wide_bus = 1'b1;
    convert(12'h5A3, 1'b0, 1'b1, len);
    check("R5 length kept", len, 12 * BIT_CYC);
    byte_sel = 1'b0;
    @(negedge clk);
    check("R5 result kept", db_val, 12'h5A3);
    chip_en = 1'b0;
    @(negedge clk);

    // R10: stand-alone mode, enables ignored, byte_sel ignored
    solo_mode = 1'b1; chip_en = 1'b0; chip_sel_n = 1'b1; wide_bus = 1'b0; byte_sel = 1'b1;
    vin = 12'h2D7;
    @(negedge clk);
    check("R10 drive while high idle", db_oe, 12'hFFF);
    rd_cnv = 1'b0;
    @(negedge clk);
    check("R10 busy after low", busy, 1);
    check("R10 released after low", db_oe, 12'h000);
    rd_cnv = 1'b1;
    len = 1;
    @(negedge clk);
    while (busy) begin len++; @(negedge clk); end
    check("R10 full length", len, 12 * BIT_CYC);
    @(negedge clk);
    check("R10 full oe", db_oe, 12'hFFF);
    check("R10 full value", db_val, 12'h2D7);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule